// File: doc/BRIEF.md
# Regulator Controller Register Slave (I2C)

This block is the serial control port of a five-channel regulator controller. It decodes a 7-bit-address I2C slave from oversampled SCL and SDA inputs and gives single-register read and write access to seven 8-bit control registers. It drives SDA only through an open-drain output enable. The registers are five per-channel voltage registers, a supervisor control register and a channel on/off register. Their contents go straight out to the analog side as parallel outputs.

Two strap inputs shape the block. One strap selects between the two bus addresses, so that two controllers can share one bus. The other strap selects the power-up code of channel A. The register pointer set by a write survives the end of that transaction, so a host can set the pointer once and later issue a bare read. A low level on the enable input puts the whole block into its default state.

Top module: `pmic_ctrl_i2c`

## Requirements
- R1: The slave acknowledges only the 7-bit address {6'b000100, a0_i} (0x08 or 0x09). Any other address is left unacknowledged and the rest of that transaction has no effect. This includes the general call address 0x00 and the address of the other strap setting.
- R2: A write transaction stores the data byte into the register selected by the pointer byte. The transaction is START, address with R/W=0, pointer byte, data byte, STOP. The slave acknowledges each of the three bytes by pulling SDA low during the ninth clock.
- R3: A read transaction returns the selected register MSB first. The transaction is START, address with R/W=0, pointer byte, repeated START, address with R/W=1, one data byte, master NACK, STOP.
- R4: The pointer keeps its value across a STOP and across transactions addressed to other slaves. A later transaction of START, address with R/W=1, one byte returns the register at that pointer.
- R5: There is no auto-increment. A second data byte in one write transaction is not acknowledged and is not stored. A master ACK after a read byte makes the slave send the same register again.
- R6: After reset the registers hold these values. Voltage registers 1, 3 and 4 (channels B, D, E) hold 0x3B and register 2 (channel C) holds 0x37. Register 0 (channel A) holds 0x23 when vsel_i is low and 0x3B when it is high. Supervisor register 5 holds 0x0A and on/off register 6 holds 0x07. SDA is released.
- R7: While en_i is low, all registers are held at their R6 defaults, using the current vsel_i level, and the bus is ignored.
- R8: In a voltage register (addresses 0 to 4), bits 4:0 are the output code on chan_code_o and bit 5 is the discharge enable on chan_dis_o. Bits 7:6 are not stored and read as 0. Bits 4:0 of register 6 drive chan_on_o, with bit 0 controlling channel A. Channel c occupies chan_code_o[5c+4:5c].
- R9: A write to a pointer above 0x06 is acknowledged and changes no register. A read from such a pointer returns 0x00.
- R10: A START or STOP in the middle of a byte abandons the transaction without any register write. A START is followed by a fresh address byte.
- R11: The slave only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Block enable; low forces defaults and idles the bus logic |
| a0_i | input | 1 | Address strap, least significant address bit |
| vsel_i | input | 1 | Strap choosing the channel A default code |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| chan_code_o | output | 25 | Output codes, channel A in bits 4:0 |
| chan_dis_o | output | 5 | Per-channel discharge enable |
| chan_on_o | output | 5 | Per-channel on/off, bit 0 is channel A |
| sup_ctrl_o | output | 8 | Supervisor control register |

## Verification
The hardest cases to reach are the two framing events in the middle of a byte. A START or STOP must land after a few data bits but before the eighth SCL rise, and the bench must then show that no register moved and that a new address byte is decoded. The bench's bit-level master can stop a byte after any bit and issue the condition there. A reference model of the register contents is compared with the parallel outputs on every clock, so a stray write shows up in the cycle it happens. The stop-separated read is reached by setting a pointer, addressing a foreign slave, and only then issuing a bare read.

// File: rtl/pmic_i2c_pkg.sv
// Shared constants and types for the regulator controller serial port.
// Assumes 7-bit addressing only; the device identifier is fixed.
package pmic_i2c_pkg;

    // Upper six address bits; the seventh comes from the strap pin
    localparam logic [5:0] DEV_ID = 6'b000100;

    // Byte-level state of the bus slave
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clock domain and finds bus events.
// Assumes the clock is many times faster than SCL, so each level is seen
// for several cycles. A START is SDA falling while SCL is high; a STOP is
// SDA rising while SCL is high. The idle bus level is high.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic start_p,
    output logic stop_p,
    output logic scl_rise,
    output logic scl_fall
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] last;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Metastability chain for one bus line, idles high
        always_ff @(posedge clk) begin : p_chain
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end

        assign synced[g] = chain[STAGES-1];
    end

    // Previous synchronised levels for edge detection
    always_ff @(posedge clk) begin : p_last
        if (!rst_n) last <= '1;
        else        last <= synced;
    end

    assign scl_s    = synced[1];
    assign sda_s    = synced[0];
    assign scl_rise = synced[1] & ~last[1];
    assign scl_fall = ~synced[1] & last[1];
    assign start_p  = synced[1] & last[1] & last[0] & ~synced[0];
    assign stop_p   = synced[1] & last[1] & ~last[0] & synced[0];

endmodule

// File: rtl/i2c_slave_fsm.sv
// Byte engine of the bus slave. It matches the address, takes a pointer
// byte and one data byte on writes, and serves one register per byte on
// reads with no pointer increment. The pointer is kept across STOP.
// Assumes synchronised line levels and single-cycle event pulses from
// i2c_line_sync, and a combinational read port that answers the pointer.
module i2c_slave_fsm
    import pmic_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       a0_i,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr_o,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);

    bus_state_t state;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic [2:0] bitcnt;
    logic       got8;
    logic       rw;
    logic       mack;

    // Bus protocol sequencing, one transition per bus event
    always_ff @(posedge clk) begin : p_bus_fsm
        if (!rst_n || !en_i) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            txreg   <= '0;
            bitcnt  <= '0;
            got8    <= 1'b0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            ptr_o   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_p) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                got8   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_p) begin
                state  <= ST_IDLE;
                got8   <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_PTR, ST_DATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8   <= 1'b0;
                            bitcnt <= '0;
                            case (state)
                                ST_ADDR: begin
                                    if (shreg[7:1] == {DEV_ID, a0_i}) begin
                                        state  <= ST_ADDR_ACK;
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                ST_PTR: begin
                                    ptr_o  <= shreg;
                                    state  <= ST_PTR_ACK;
                                    sda_oe <= 1'b1;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr_o;
                                    wr_data <= shreg;
                                    state   <= ST_DATA_ACK;
                                    sda_oe  <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                state  <= ST_TX;
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                state  <= ST_PTR;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_PTR_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_DATA;
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_IDLE;
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                state  <= ST_TX_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= ~txreg[6];
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (mack) begin
                                state  <= ST_TX;
                                txreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // SDA is only pulled low while SCL is low
    p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // A STOP returns the engine to idle with the line released
    p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && stop_p) |=> (state == ST_IDLE && !sda_oe));

    // A START always restarts address decoding and never writes
    p_start_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_p) |=> (state == ST_ADDR && !wr_en));

    // At most one register write per byte
    p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // A write pulse is always followed by the acknowledge of that byte
    p_write_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && wr_en) |-> (state == ST_DATA_ACK && sda_oe));

endmodule

// File: rtl/pmic_reg_bank.sv
// Control register store: per-channel voltage registers, supervisor
// control and channel on/off. Voltage registers keep six bits (code plus
// discharge enable). Writes outside the map are dropped, and reads there
// give zero. A low enable or reset loads the defaults, with the channel A
// code taken from the select strap.
module pmic_reg_bank #(
    parameter int                  NCH       = 5,
    parameter int                  CODE_W    = 5,
    parameter logic [NCH*CODE_W-1:0] CODE_DEF  = {5'b11011, 5'b11011, 5'b10111, 5'b11011, 5'b00011},
    parameter logic [CODE_W-1:0]   CODE_A_LO = 5'b00011,
    parameter logic [CODE_W-1:0]   CODE_A_HI = 5'b11011,
    parameter logic [7:0]          SUP_DEF   = 8'h0A,
    parameter logic [7:0]          ONOFF_DEF = 8'h07
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  vsel_i,
    input  logic                  wr_en,
    input  logic [7:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [NCH*CODE_W-1:0] chan_code_o,
    output logic [NCH-1:0]        chan_dis_o,
    output logic [NCH-1:0]        chan_on_o,
    output logic [7:0]            sup_o
);

    localparam logic [7:0] ADR_SUP   = 8'(NCH);
    localparam logic [7:0] ADR_ONOFF = 8'(NCH + 1);

    logic [CODE_W:0] vq_all [NCH];
    logic [7:0]      sup_q;
    logic [7:0]      onoff_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [7:0] MY_ADR = 8'(c);
        logic [CODE_W-1:0] def_code;
        logic [CODE_W:0]   vq;

        if (c == 0) begin : g_strap
            assign def_code = vsel_i ? CODE_A_HI : CODE_A_LO;
        end else begin : g_fixed
            assign def_code = CODE_DEF[c*CODE_W +: CODE_W];
        end

        // Voltage register of one channel
        always_ff @(posedge clk) begin : p_volt
            if (!rst_n || !en_i)                 vq <= {1'b1, def_code};
            else if (wr_en && wr_addr == MY_ADR) vq <= wr_data[CODE_W:0];
        end

        assign vq_all[c]                       = vq;
        assign chan_code_o[c*CODE_W +: CODE_W] = vq[CODE_W-1:0];
        assign chan_dis_o[c]                   = vq[CODE_W];

        // A write to this channel lands on the next edge
        p_chan_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i && $past(en_i && wr_en && wr_addr == MY_ADR))
                |-> (vq == $past(wr_data[CODE_W:0])));
    end

    // Supervisor and on/off registers
    always_ff @(posedge clk) begin : p_ctrl_regs
        if (!rst_n || !en_i) begin
            sup_q   <= SUP_DEF;
            onoff_q <= ONOFF_DEF;
        end else if (wr_en) begin
            if (wr_addr == ADR_SUP)   sup_q   <= wr_data;
            if (wr_addr == ADR_ONOFF) onoff_q <= wr_data;
        end
    end

    // Read port addressed by the bus pointer
    always_comb begin : p_read_mux
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == 8'(c)) rd_data = 8'(vq_all[c]);
        end
        if (rd_addr == ADR_SUP)   rd_data = sup_q;
        if (rd_addr == ADR_ONOFF) rd_data = onoff_q;
    end

    assign sup_o     = sup_q;
    assign chan_on_o = onoff_q[NCH-1:0];

    // Writes beyond the map leave the control registers untouched
    p_oob_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i && wr_en && wr_addr > ADR_ONOFF))
            |-> ($stable(sup_q) && $stable(onoff_q)));

    // With no write, the control registers hold
    p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && !$past(wr_en))
            |-> ($stable(sup_q) && $stable(onoff_q)));

endmodule

// File: rtl/pmic_ctrl_i2c.sv
// Top of the regulator controller serial port. It joins the line
// synchroniser, the byte engine and the register store, and brings the
// register contents out as parallel controls. Assumes SCL and SDA are
// open-drain bus lines read back through scl_i and sda_i.
module pmic_ctrl_i2c #(
    parameter int NCH         = 5,
    parameter int CODE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  a0_i,
    input  logic                  vsel_i,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NCH*CODE_W-1:0] chan_code_o,
    output logic [NCH-1:0]        chan_dis_o,
    output logic [NCH-1:0]        chan_on_o,
    output logic [7:0]            sup_ctrl_o
);

    logic       scl_s, sda_s, start_p, stop_p, scl_rise, scl_fall;
    logic [7:0] rd_data, ptr;
    logic       wr_en;
    logic [7:0] wr_addr, wr_data;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_slave_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .a0_i     (a0_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .start_p  (start_p),
        .stop_p   (stop_p),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .rd_data  (rd_data),
        .ptr_o    (ptr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe_o)
    );

    pmic_reg_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .vsel_i      (vsel_i),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (ptr),
        .rd_data     (rd_data),
        .chan_code_o (chan_code_o),
        .chan_dis_o  (chan_dis_o),
        .chan_on_o   (chan_on_o),
        .sup_o       (sup_ctrl_o)
    );

endmodule

// File: tb/pmic_ctrl_i2c_tb.sv
// Bench: bit-level bus master plus a behavioural register model compared
// with the parallel outputs on every clock.
module pmic_ctrl_i2c_tb;

    localparam int Q = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, en = 1'b1, a0 = 1'b0, vsel = 1'b0;
    logic scl_m = 1'b1, sda_m_low = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic [24:0] chan_code;
    logic [4:0]  chan_dis, chan_on;
    logic [7:0]  sup_ctrl;

    assign sda_line = !(sda_m_low || sda_oe);

    pmic_ctrl_i2c u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .a0_i(a0), .vsel_i(vsel),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .chan_code_o(chan_code), .chan_dis_o(chan_dis),
        .chan_on_o(chan_on), .sup_ctrl_o(sup_ctrl)
    );

    int   checks = 0, fails = 0;
    bit   cmp_en = 0, finished = 0;
    logic [7:0] mreg [7];
    logic rst_p, en_p, vsel_p, oe_q = 1'b0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            if (fails < 30) $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] dflt(input int r, input logic v);
        case (r)
            0: return v ? 8'h3B : 8'h23;
            2: return 8'h37;
            5: return 8'h0A;
            6: return 8'h07;
            default: return 8'h3B;
        endcase
    endfunction

    always @(posedge clk) begin
        rst_p  <= rst_n;
        en_p   <= en;
        vsel_p <= vsel;
    end

    // Model upkeep and per-clock comparison (R7, R8, R11)
    always @(negedge clk) begin
        logic [24:0] ec;
        logic [4:0]  ed;
        if (rst_p !== 1'b1 || en_p !== 1'b1)
            for (int r = 0; r < 7; r++) mreg[r] = dflt(r, vsel_p);
        if (cmp_en) begin
            for (int c = 0; c < 5; c++) begin
                ec[c*5 +: 5] = mreg[c][4:0];
                ed[c]        = mreg[c][5];
            end
            chk("R8 model chan_code", 32'(chan_code), 32'(ec));
            chk("R8 model chan_dis", 32'(chan_dis), 32'(ed));
            chk("R8 model chan_on", 32'(chan_on), 32'(mreg[6][4:0]));
            chk("R7 model sup_ctrl", 32'(sup_ctrl), 32'(mreg[5]));
        end
        if (sda_oe && !oe_q) chk("R11 oe rise with scl low", 32'(scl_m), 32'd0);
        oe_q = sda_oe;
    end

    task automatic qwait(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic b_start();
        sda_m_low = 1'b0; scl_m = 1'b1; qwait(1);
        sda_m_low = 1'b1; qwait(1);
        scl_m = 1'b0; qwait(1);
    endtask

    task automatic b_rstart();
        sda_m_low = 1'b0; qwait(1);
        scl_m = 1'b1; qwait(1);
        sda_m_low = 1'b1; qwait(1);
        scl_m = 1'b0; qwait(1);
    endtask

    task automatic b_stop();
        sda_m_low = 1'b1; qwait(1);
        scl_m = 1'b1; qwait(1);
        sda_m_low = 1'b0; qwait(2);
    endtask

    task automatic b_bit(input logic b);
        sda_m_low = !b; qwait(1);
        scl_m = 1'b1; qwait(2);
        scl_m = 1'b0; qwait(1);
    endtask

    task automatic b_wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) b_bit(b[i]);
        sda_m_low = 1'b0; qwait(1);
        scl_m = 1'b1; qwait(1);
        ack = !sda_line; qwait(1);
        scl_m = 1'b0; qwait(1);
    endtask

    task automatic b_rbyte(input bit mack, output logic [7:0] d);
        sda_m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qwait(1); scl_m = 1'b1;
            qwait(1); d[i] = sda_line;
            qwait(1); scl_m = 1'b0;
        end
        qwait(1);
        b_bit(!mack);
        sda_m_low = 1'b0;
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] ra,
                            input logic [7:0] d, output bit a1, output bit a2, output bit a3);
        b_start();
        b_wbyte({dev, 1'b0}, a1);
        b_wbyte(ra, a2);
        cmp_en = 0;
        b_wbyte(d, a3);
        if (a1 && a3 && ra < 8'd7) mreg[ra[2:0]] = (ra < 8'd5) ? (d & 8'h3F) : d;
        cmp_en = 1;
        b_stop();
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] ra,
                           output logic [7:0] d, output bit a1);
        bit a2, a3;
        b_start();
        b_wbyte({dev, 1'b0}, a1);
        b_wbyte(ra, a2);
        b_rstart();
        b_wbyte({dev, 1'b1}, a3);
        b_rbyte(1'b0, d);
        b_stop();
        a1 = a1 & a2 & a3;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit a1, a2, a3, a4;
        logic [7:0] rd, rd2;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state at the ports
        chk("R6 reset chan_code", 32'(chan_code), 32'({5'b11011, 5'b11011, 5'b10111, 5'b11011, 5'b00011}));
        chk("R6 reset chan_dis", 32'(chan_dis), 32'h1F);
        chk("R6 reset chan_on", 32'(chan_on), 32'h07);
        chk("R6 reset sup_ctrl", 32'(sup_ctrl), 32'h0A);
        chk("R6 reset sda released", 32'(sda_oe), 32'd0);
        cmp_en = 1;
        qwait(2);

        // R3/R6: combined read of every default
        for (int r = 0; r < 7; r++) begin
            do_read(7'h08, 8'(r), rd, a1);
            chk("R3 read ack", 32'(a1), 32'd1);
            chk("R6 default readback", 32'(rd), 32'(dflt(r, 1'b0)));
        end

        // R1: foreign address and general call ignored
        do_write(7'h09, 8'h05, 8'hFF, a1, a2, a3);
        chk("R1 other strap address nack", 32'(a1), 32'd0);
        do_write(7'h00, 8'h06, 8'h00, a1, a2, a3);
        chk("R1 general call nack", 32'(a1), 32'd0);

        // R2/R8: write then read back, bits 7:6 dropped
        do_write(7'h08, 8'h02, 8'hD5, a1, a2, a3);
        chk("R2 write acks", 32'({a1, a2, a3}), 32'b111);
        do_read(7'h08, 8'h02, rd, a1);
        chk("R8 bits 7:6 read zero", 32'(rd), 32'h15);
        do_write(7'h08, 8'h06, 8'h1A, a1, a2, a3);
        chk("R8 on/off to chan_on", 32'(chan_on), 32'h1A);

        // R4: pointer survives STOP and a foreign transaction
        b_start(); b_wbyte({7'h08, 1'b0}, a1); b_wbyte(8'h05, a2); b_stop();
        do_read(7'h30, 8'h00, rd, a1);
        chk("R4 foreign slave nack", 32'(a1), 32'd0);
        b_start(); b_wbyte({7'h08, 1'b1}, a1); b_rbyte(1'b0, rd); b_stop();
        chk("R4 bare read ack", 32'(a1), 32'd1);
        chk("R4 bare read data", 32'(rd), 32'h0A);

        // R5: second data byte refused, master ACK repeats register
        b_start(); b_wbyte({7'h08, 1'b0}, a1); b_wbyte(8'h03, a2);
        cmp_en = 0;
        b_wbyte(8'h01, a3);
        mreg[3] = 8'h01;
        cmp_en = 1;
        b_wbyte(8'h1F, a4); b_stop();
        chk("R5 first data ack", 32'(a3), 32'd1);
        chk("R5 second data nack", 32'(a4), 32'd0);
        b_start(); b_wbyte({7'h08, 1'b0}, a1); b_wbyte(8'h03, a2); b_rstart();
        b_wbyte({7'h08, 1'b1}, a3); b_rbyte(1'b1, rd); b_rbyte(1'b0, rd2); b_stop();
        chk("R5 first read byte", 32'(rd), 32'h01);
        chk("R5 repeated read byte", 32'(rd2), 32'h01);

        // R9: pointer beyond map
        do_write(7'h08, 8'h07, 8'h55, a1, a2, a3);
        chk("R9 oob write acked", 32'({a1, a2, a3}), 32'b111);
        do_read(7'h08, 8'h07, rd, a1);
        chk("R9 oob read zero", 32'(rd), 32'h00);
        do_write(7'h08, 8'hFF, 8'hAA, a1, a2, a3);
        do_read(7'h08, 8'hFF, rd, a1);
        chk("R9 pointer FF read zero", 32'(rd), 32'h00);

        // R10: STOP in the middle of the data byte
        b_start(); b_wbyte({7'h08, 1'b0}, a1); b_wbyte(8'h01, a2);
        for (int i = 0; i < 4; i++) b_bit(1'b0);
        b_stop();
        do_read(7'h08, 8'h01, rd, a1);
        chk("R10 stop abort keeps reg1", 32'(rd), 32'h3B);
        // R10: repeated START in the middle of the data byte, then bare read
        b_start(); b_wbyte({7'h08, 1'b0}, a1); b_wbyte(8'h04, a2);
        for (int i = 0; i < 3; i++) b_bit(1'b0);
        b_rstart(); b_wbyte({7'h08, 1'b1}, a3); b_rbyte(1'b0, rd); b_stop();
        chk("R10 restart decodes address", 32'(a3), 32'd1);
        chk("R10 restart abort keeps reg4", 32'(rd), 32'h3B);

        // R1: other strap setting
        a0 = 1'b1;
        qwait(1);
        do_write(7'h09, 8'h04, 8'h2A, a1, a2, a3);
        chk("R1 strap high address ack", 32'({a1, a2, a3}), 32'b111);
        do_write(7'h08, 8'h04, 8'h00, a1, a2, a3);
        chk("R1 strap high rejects 0x08", 32'(a1), 32'd0);
        a0 = 1'b0;
        qwait(1);

        // R7: enable low restores defaults with the strap level, bus ignored
        vsel = 1'b1;
        en = 1'b0;
        qwait(2);
        chk("R7 en low channel A code", 32'(chan_code[4:0]), 32'h1B);
        chk("R7 en low chan_on", 32'(chan_on), 32'h07);
        do_write(7'h08, 8'h05, 8'h77, a1, a2, a3);
        chk("R7 bus ignored while disabled", 32'(a1), 32'd0);
        chk("R7 sup held at default", 32'(sup_ctrl), 32'h0A);
        en = 1'b1;
        qwait(1);
        vsel = 1'b0;
        qwait(1);
        do_read(7'h08, 8'h00, rd, a1);
        chk("R7 channel A default kept", 32'(rd), 32'h3B);
        do_read(7'h08, 8'h02, rd, a1);
        chk("R7 channel C restored", 32'(rd), 32'h37);

        qwait(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule